// File: doc/BRIEF.md
# Hybrid Additive Cellular-Automaton Pattern Generator

This block is a row of N one-bit cells that steps once per clock and produces a pseudo-random test pattern. Each cell computes its next value from three inputs: its left neighbour, itself and its right neighbour. It combines the inputs it has been told to use with XOR. When the cell's inversion bit is set, it uses XNOR instead. Taken together, the per-cell selections form a tridiagonal dependency matrix over GF(2). The inversion bits form a constant vector that is added to the product. The cells at the two ends see a constant 0 where a neighbour is missing.

A rule set is normally chosen offline. A suitable choice is invertible, so every state lies on some cycle. A non-maximal-length choice can split the state space into several cycles of different lengths. The rule set, a seed and a pattern budget are all captured with one load strobe. After the load, the generator advances on each enabled clock until it has issued exactly the budgeted number of steps. It then raises a done flag and freezes, so that only a chosen window of a long cycle is ever produced.

Top module: `ca_pattern_gen`

## Requirements
- R1: After synchronous reset, pattern is 0 and done is 0, and asserting enable causes no change in pattern until a load has occurred.
- R2: A clock edge with load high puts seed on pattern after that edge, captures the rule vectors and the limit, and clears the step count; done then equals 1 only when the captured limit is 0.
- R3: On each step, cell i becomes (left_sel[i] & cell i-1) ^ (self_sel[i] & cell i) ^ (right_sel[i] & cell i+1) ^ invert[i]. The bit i of every vector belongs to cell i, and cell -1 and cell N are read as 0.
- R4: With N=5, a dependency matrix whose rows for cells 0..4 are 10000, 01100, 01110, 00011 and 00001 (columns ordered cell 0..4), and inversion on cells 0, 2 and 4, every step equals that matrix times the state plus the inversion vector over GF(2).
- R5: While enable is low and load is low, pattern holds its value.
- R6: After exactly limit steps, done goes high and pattern stops changing, even with enable held high, until the next load.
- R7: A load with limit 0 gives done high right after the load, and pattern stays at the seed.
- R8: The rule, seed and limit inputs have no effect except on a clock edge with load high.
- R9: For an invertible rule set (for example N=7, with all three selections set in every cell), a run from any seed returns to that seed after exactly its cycle length, and not at any earlier step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture seed, rules and limit |
| seed | input | N | Starting state |
| left_sel | input | N | Per-cell use of left neighbour |
| self_sel | input | N | Per-cell use of own state |
| right_sel | input | N | Per-cell use of right neighbour |
| invert | input | N | Per-cell XNOR select |
| enable | input | 1 | Allow stepping |
| limit | input | CNT_W | Number of steps in the window |
| pattern | output | N | Current state / test pattern |
| done | output | 1 | Window exhausted |

## Verification
The bench steps the five-cell example and compares each step with a row-by-row matrix product. A mistake in the boundary handling or in the neighbour direction would produce wrong bits at the end cells. A missed complement would show up as a constant offset in the cells 0, 2 and 4. The seven-cell run checks that the state returns to the seed at exactly the cycle length that a software model finds. A design that stepped twice, or dropped a term, would miss that return.

The window tests cover a limit of zero and steps that continue past the limit. An off-by-one counter would issue one pattern too many or one too few. The bench also changes the rule inputs after a load; a design that reads them live would produce a different sequence.

// File: rtl/ca_pkg.sv
package ca_pkg;
  // One cell of the additive rule: selected neighbours XORed, plus inversion.
  function automatic logic ca_next_bit(input logic lft, input logic slf,
                                       input logic rgt, input logic use_l,
                                       input logic use_s, input logic use_r,
                                       input logic inv);
    return (use_l & lft) ^ (use_s & slf) ^ (use_r & rgt) ^ inv;
  endfunction
endpackage

// File: rtl/ca_rule_bank.sv
module ca_rule_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] left_in,
  input  logic [N-1:0] self_in,
  input  logic [N-1:0] right_in,
  input  logic [N-1:0] inv_in,
  output logic [N-1:0] left_q,
  output logic [N-1:0] self_q,
  output logic [N-1:0] right_q,
  output logic [N-1:0] inv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      self_q  <= '0;
      right_q <= '0;
      inv_q   <= '0;
    end else if (load) begin
      left_q  <= left_in;
      self_q  <= self_in;
      right_q <= right_in;
      inv_q   <= inv_in;
    end
  end

  // Rules change only on a load edge.
  assert_rules_only_on_load_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(left_q) && $stable(self_q) && $stable(right_q) && $stable(inv_q)));
endmodule

// File: rtl/ca_cell.sv
module ca_cell
  import ca_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic seed_bit,
  input  logic advance,
  input  logic left_nb,
  input  logic right_nb,
  input  logic use_l,
  input  logic use_s,
  input  logic use_r,
  input  logic inv,
  output logic q
);
  logic next_bit;
  assign next_bit = ca_next_bit(left_nb, q, right_nb, use_l, use_s, use_r, inv);

  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (load)    q <= seed_bit;
    else if (advance) q <= next_bit;
  end

  // A cell that uses no neighbour at all simply takes its inversion bit.
  assert_isolated_cell_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && !use_l && !use_s && !use_r) |=> (q == $past(inv)));
endmodule

// File: rtl/ca_window_ctr.sv
module ca_window_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit_in,
  output logic             advance,
  output logic             done,
  output logic [CNT_W-1:0] count_q
);
  logic [CNT_W-1:0] limit_q;
  logic             budget_left;
  logic [CNT_W-1:0] count_inc;

  assign budget_left = (count_q != limit_q);
  assign advance     = enable && !load && budget_left;
  assign count_inc   = count_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      limit_q <= '0;
      done    <= 1'b0;
    end else if (load) begin
      count_q <= '0;
      limit_q <= limit_in;
      done    <= (limit_in == '0);
    end else if (advance) begin
      count_q <= count_inc;
      if (count_inc == limit_q) done <= 1'b1;
    end
  end

  assert_count_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    count_q <= limit_q);
  assert_done_at_limit_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (count_q == limit_q));
  assert_load_clears_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q == '0));
  assert_no_step_when_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !advance);
endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen #(
  parameter int N     = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [N-1:0]     seed,
  input  logic [N-1:0]     left_sel,
  input  logic [N-1:0]     self_sel,
  input  logic [N-1:0]     right_sel,
  input  logic [N-1:0]     invert,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit,
  output logic [N-1:0]     pattern,
  output logic             done
);
  logic [N-1:0]     l_q, s_q, r_q, f_q;
  logic [N-1:0]     state;
  logic [N-1:0]     left_nb, right_nb;
  logic             advance;
  logic [CNT_W-1:0] step_count;

  ca_rule_bank #(.N(N)) u_rules (
    .clk(clk), .rst(rst), .load(load),
    .left_in(left_sel), .self_in(self_sel), .right_in(right_sel), .inv_in(invert),
    .left_q(l_q), .self_q(s_q), .right_q(r_q), .inv_q(f_q)
  );

  ca_window_ctr #(.CNT_W(CNT_W)) u_window (
    .clk(clk), .rst(rst), .load(load), .enable(enable), .limit_in(limit),
    .advance(advance), .done(done), .count_q(step_count)
  );

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_cell
      if (i == 0) begin : g_lo
        assign left_nb[i] = 1'b0;
      end else begin : g_lm
        assign left_nb[i] = state[i-1];
      end
      if (i == N-1) begin : g_hi
        assign right_nb[i] = 1'b0;
      end else begin : g_hm
        assign right_nb[i] = state[i+1];
      end
      ca_cell u_cell (
        .clk(clk), .rst(rst), .load(load), .seed_bit(seed[i]), .advance(advance),
        .left_nb(left_nb[i]), .right_nb(right_nb[i]),
        .use_l(l_q[i]), .use_s(s_q[i]), .use_r(r_q[i]), .inv(f_q[i]),
        .q(state[i])
      );
    end
  endgenerate

  assign pattern = state;

  assert_seed_loaded_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (pattern == $past(seed)));
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !enable) |=> $stable(pattern));
  assert_frozen_when_done_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> $stable(pattern));
  assert_count_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    (advance && !load) |=> (step_count == $past(step_count) + CNT_W'(1)));
endmodule

// File: tb/ca_pattern_gen_test.sv
module ca_pattern_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // five-cell instance
  logic        load5 = 0, en5 = 0, done5;
  logic [4:0]  seed5 = 0, l5 = 0, s5 = 0, r5 = 0, f5 = 0, pat5;
  logic [15:0] lim5 = 0;
  // seven-cell instance
  logic        load7 = 0, en7 = 0, done7;
  logic [6:0]  seed7 = 0, l7 = 0, s7 = 0, r7 = 0, f7 = 0, pat7;
  logic [15:0] lim7 = 0;

  ca_pattern_gen #(.N(5), .CNT_W(16)) uut (
    .clk(clk), .rst(rst), .load(load5), .seed(seed5), .left_sel(l5), .self_sel(s5),
    .right_sel(r5), .invert(f5), .enable(en5), .limit(lim5), .pattern(pat5), .done(done5));

  ca_pattern_gen #(.N(7), .CNT_W(16)) uut7 (
    .clk(clk), .rst(rst), .load(load7), .seed(seed7), .left_sel(l7), .self_sel(s7),
    .right_sel(r7), .invert(f7), .enable(en7), .limit(lim7), .pattern(pat7), .done(done7));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Matrix model of the example: row string bit 4 is column of cell 0.
  function automatic logic [4:0] model5(input logic [4:0] x);
    logic [4:0] rows [5];
    logic [4:0] y;
    rows[0] = 5'b10000; rows[1] = 5'b01100; rows[2] = 5'b01110;
    rows[3] = 5'b00011; rows[4] = 5'b00001;
    for (int i = 0; i < 5; i++) begin
      logic acc = 1'b0;
      for (int j = 0; j < 5; j++) if (rows[i][4-j]) acc ^= x[j];
      y[i] = acc ^ (i % 2 == 0);
    end
    return y;
  endfunction

  // Seven cells, all three neighbours used, no inversion, zero at the ends.
  function automatic logic [6:0] model7(input logic [6:0] x);
    logic [8:0] ext = {1'b0, x, 1'b0};
    logic [6:0] y;
    for (int i = 0; i < 7; i++) y[i] = ext[i] ^ ext[i+1] ^ ext[i+2];
    return y;
  endfunction

  task automatic load_example(input logic [4:0] sd, input logic [15:0] lim);
    @(negedge clk);
    seed5 = sd; l5 = 5'b00100; s5 = 5'b11111; r5 = 5'b01110; f5 = 5'b10101;
    lim5 = lim; load5 = 1; en5 = 0;
    @(negedge clk);
    load5 = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(pat5 == 0, "R1 reset pattern", pat5, 0);
    check(done5 == 0, "R1 reset done", done5, 0);
    en5 = 1; en7 = 1;
    repeat (3) @(negedge clk);
    check(pat5 == 0 && pat7 == 0, "R1 no step before load", pat5, 0);
    en5 = 0; en7 = 0;
  endtask

  task automatic t_example;
    logic [4:0] m = 5'b00110;
    load_example(m, 16'd12);
    check(pat5 == m, "R2 seed on pattern", pat5, m);
    check(done5 == 0, "R2 done low with nonzero limit", done5, 0);
    en5 = 1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      m = model5(m);
      check(pat5 == m, "R4 example step", pat5, m);
      check(done5 == (k == 11), "R6 done timing", done5, k == 11);
    end
    repeat (3) @(negedge clk);
    check(pat5 == m, "R6 frozen past limit", pat5, m);
    check(done5 == 1, "R6 done stays", done5, 1);
    en5 = 0;
  endtask

  task automatic t_hold;
    logic [4:0] m = 5'b11001;
    load_example(m, 16'd50);
    en5 = 1;
    @(negedge clk); m = model5(m);
    en5 = 0;
    repeat (4) @(negedge clk);
    check(pat5 == m, "R5 hold while disabled", pat5, m);
    en5 = 1;
    @(negedge clk); m = model5(m);
    check(pat5 == m, "R3 resume after hold", pat5, m);
    en5 = 0;
  endtask

  task automatic t_zero_limit;
    load_example(5'b01011, 16'd0);
    check(done5 == 1, "R7 done after zero-limit load", done5, 1);
    en5 = 1;
    repeat (3) @(negedge clk);
    check(pat5 == 5'b01011, "R7 no step with zero limit", pat5, 5'b01011);
    en5 = 0;
  endtask

  task automatic t_ignore;
    logic [4:0] m = 5'b10010;
    load_example(m, 16'd4);
    // change every captured input; behaviour must not follow them
    l5 = 5'b11111; s5 = 5'b00000; r5 = 5'b00000; f5 = 5'b00000;
    seed5 = 5'b11111; lim5 = 16'd1;
    en5 = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); m = model5(m);
      check(pat5 == m, "R8 live rule inputs ignored", pat5, m);
    end
    check(done5 == 1, "R8 captured limit used", done5, 1);
    en5 = 0;
  endtask

  task automatic t_cycle7;
    logic [6:0] sd = 7'b0010011;
    logic [6:0] m;
    int period = 0;
    m = sd;
    for (int k = 1; k <= 200; k++) begin
      m = model7(m);
      if (m == sd && period == 0) period = k;
    end
    check(period > 0, "R9 model finds cycle", period, 1);
    @(negedge clk);
    seed7 = sd; l7 = '1; s7 = '1; r7 = '1; f7 = '0; lim7 = 16'(period); load7 = 1;
    @(negedge clk);
    load7 = 0; en7 = 1;
    m = sd;
    for (int k = 1; k <= period; k++) begin
      @(negedge clk); m = model7(m);
      check(pat7 == m, "R3 seven-cell step", pat7, m);
      if (k < period) check(pat7 != sd, "R9 no early return", pat7, sd);
    end
    check(pat7 == sd, "R9 returns to seed at cycle length", pat7, sd);
    check(done7 == 1, "R9 done at cycle length", done7, 1);
    en7 = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_example();
    t_hold();
    t_zero_limit();
    t_ignore();
    t_cycle7();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule